// File: doc/BRIEF.md
# Multiplexed LCD segment scan controller

This block stores the on/off pattern for a small liquid-crystal panel and scans it out as logical drive states. The pattern sits in a 24-word by 4-bit display RAM: the word address picks a segment column and the bit index picks a backplane row. A frame-rate tick from outside steps the scan through one, two, three or four backplane phases, as a 2-bit mode input selects. In each phase the segments show the RAM row that belongs to the active backplane.

Segment data reaches the outputs through two registers. A staging register keeps fetching the row for the coming phase while the display register holds the row being shown. At each tick the staged row moves into the display register, so segment outputs change only on phase boundaries. Each completed frame inverts the drive polarity, so the panel sees no net DC.

The RAM is loaded through a valid/ready write stream. A beat moves when `wr_valid` and `wr_ready` are both high at a rising edge. The block lowers `wr_ready` for exactly the cycles in which `frame_tick` is high. The writer must then hold its beat until the next cycle in which ready is high. A beat whose address is 24 or more is accepted and discarded.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `seg_on` and `seg_lvl` are all zero, `drive_pol` is 0, the phase is 0 and every RAM bit reads 0.
- R2: `wr_ready` equals the inverse of `frame_tick`. A beat is stored only if `wr_valid` and `wr_ready` are both high and `wr_addr` is below 24. Any other beat leaves the RAM unchanged.
- R3: In the phase for backplane row p, `seg_on[i]` equals bit p of RAM word i. A 1 means the segment is on.
- R4: The mode encoding is 00 static (1 phase), 01 two-phase, 10 three-phase, 11 four-phase. At a tick the phase advances by one, and wraps to 0 from the last phase of the mode, or from any phase that lies outside the mode.
- R5: In mode 11, `bp_active` is the one-hot value 1<<phase, so each backplane has its own phase.
- R6: In mode 10, phases 0, 1 and 2 activate bits 0, 1 and 2, and bit 3 is always equal to bit 1.
- R7: In mode 01, bits 0 and 2 are active in phase 0, and bits 1 and 3 are active in phase 1.
- R8: In mode 00, all four `bp_active` bits are high in phase 0.
- R9: `seg_on` changes only in the cycle after a tick. The new row reflects every write accepted at least two cycles before the tick cycle. The mode must be held steady for at least one cycle before a tick.
- R10: `drive_pol` toggles at every tick whose new phase is 0. `seg_lvl[i]` is `~drive_pol` when the segment is on and `drive_pol` when it is off. `bp_lvl[k]` is `drive_pol` when backplane k is active and `~drive_pol` when it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Multiplex mode select |
| frame_tick | input | 1 | Phase advance strobe |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted |
| wr_addr | input | 5 | RAM column address |
| wr_data | input | 4 | RAM word, bit n = row n |
| seg_on | output | 24 | Segment on/off for the current phase |
| seg_lvl | output | 24 | Segment drive level relative to polarity |
| bp_active | output | 4 | Backplanes active in the current phase |
| bp_lvl | output | 4 | Backplane drive level |
| drive_pol | output | 1 | Frame polarity |

## Verification
A wrong phase count shows up on `bp_active` and `bp_lvl` in the very cycle after the faulty tick, and on `seg_on` at that same edge. A corrupted staging fetch stays hidden until the next tick, when it moves into `seg_on`. A bad RAM bit appears only once its row is scanned, which is at most four ticks later. A polarity slip flips every level output at once, and it persists through later frames, so per-cycle comparison against a reference model catches each of these as soon as it becomes visible.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    MUX_STATIC = 2'b00,
    MUX_DUAL   = 2'b01,
    MUX_TRIPLE = 2'b10,
    MUX_QUAD   = 2'b11
  } mux_mode_e;
endpackage

// File: rtl/lcd_row_ram.sv
module lcd_row_ram #(
  parameter int SEG_N  = 24,
  parameter int BP_N   = 4,
  parameter int ADDR_W = 5,
  parameter int PH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BP_N-1:0]   wdata,
  input  logic [PH_W-1:0]   rd_row,
  output logic [SEG_N-1:0]  rd_data
);
  logic [BP_N-1:0] mem [SEG_N];
  logic            addr_ok;

  assign addr_ok = (waddr < ADDR_W'(SEG_N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_N; i++) mem[i] <= '0;
    end else if (we && addr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < SEG_N; g++) begin : g_col
    assign rd_data[g] = mem[g][rd_row];
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr_ok) |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_scan_pkg::*;
#(
  parameter int BP_N = 4,
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            tick,
  output logic [PH_W-1:0] fetch_row,
  output logic            pol,
  output logic [BP_N-1:0] bp_active
);
  logic [PH_W-1:0] ph, ph_upd;
  logic [PH_W:0]   n_ph;

  assign n_ph = (PH_W + 1)'(mode) + (PH_W + 1)'(1);

  function automatic logic [PH_W-1:0] step(input logic [PH_W-1:0] p,
                                           input logic [PH_W:0]   n);
    if (({1'b0, p} + (PH_W + 1)'(1)) >= n) return '0;
    return p + PH_W'(1);
  endfunction

  assign ph_upd    = tick ? step(ph, n_ph) : ph;
  assign fetch_row = step(ph_upd, n_ph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= '0;
      pol <= 1'b0;
    end else if (tick) begin
      ph <= ph_upd;
      if (ph_upd == '0) pol <= ~pol;
    end
  end

  for (genvar k = 0; k < BP_N; k++) begin : g_bp
    int slot;
    always_comb begin
      if (k < int'(n_ph))       slot = k;
      else if (int'(n_ph) == 3) slot = 1;
      else                      slot = k % int'(n_ph);
    end
    assign bp_active[k] = (int'(ph) == slot);
  end

  // R10
  pol_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ph_upd == '0) |=> pol != $past(pol));
  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(ph) && $stable(pol)));
  // R5
  quad_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MUX_QUAD) |-> $countones(bp_active) == 1);
  // R6
  triple_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MUX_TRIPLE) |-> bp_active[3] == bp_active[1]);
  // R7
  dual_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MUX_DUAL) |-> (bp_active[0] == bp_active[2] && bp_active[1] == bp_active[3]));
  // R8
  static_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MUX_STATIC) |-> (bp_active == '0 || bp_active == '1));
endmodule

// File: rtl/lcd_seg_pipe.sv
module lcd_seg_pipe #(
  parameter int SEG_N = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEG_N-1:0] row_in,
  output logic [SEG_N-1:0] seg_on
);
  logic [SEG_N-1:0] stage_q, disp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      disp_q  <= '0;
    end else begin
      stage_q <= row_in;
      if (tick) disp_q <= stage_q;
    end
  end

  assign seg_on = disp_q;

  // R9
  disp_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(disp_q));
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int SEG_N  = 24,
  parameter int BP_N   = 4,
  parameter int ADDR_W = 5,
  localparam int PH_W  = (BP_N > 1) ? $clog2(BP_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              frame_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BP_N-1:0]   wr_data,
  output logic [SEG_N-1:0]  seg_on,
  output logic [SEG_N-1:0]  seg_lvl,
  output logic [BP_N-1:0]   bp_active,
  output logic [BP_N-1:0]   bp_lvl,
  output logic              drive_pol
);
  logic             we;
  logic [PH_W-1:0]  fetch_row;
  logic [SEG_N-1:0] row_data;

  assign wr_ready = ~frame_tick;
  assign we       = wr_valid & wr_ready;

  lcd_row_ram #(.SEG_N(SEG_N), .BP_N(BP_N), .ADDR_W(ADDR_W), .PH_W(PH_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(wr_addr), .wdata(wr_data),
    .rd_row(fetch_row), .rd_data(row_data)
  );

  lcd_phase_seq #(.BP_N(BP_N), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(frame_tick),
    .fetch_row(fetch_row), .pol(drive_pol), .bp_active(bp_active)
  );

  lcd_seg_pipe #(.SEG_N(SEG_N)) u_pipe (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .row_in(row_data), .seg_on(seg_on)
  );

  assign seg_lvl = seg_on ^ {SEG_N{drive_pol}};
  assign bp_lvl  = ~(bp_active ^ {BP_N{drive_pol}});

  // R2
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> !wr_ready);
endmodule

// File: tb/tb_lcd_scan_ctrl.sv
module tb_lcd_scan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic        frame_tick = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [4:0]  wr_addr = '0;
  logic [3:0]  wr_data = '0;
  logic [23:0] seg_on, seg_lvl;
  logic [3:0]  bp_active, bp_lvl;
  logic        drive_pol;

  int checks = 0, fails = 0;
  bit done = 0;

  lcd_scan_ctrl dut (.*);

  always #5 clk = ~clk;

  // reference model state
  logic [3:0]  m_ram [24];
  logic [23:0] m_stage, m_disp;
  int          m_ph;
  logic        m_pol;

  function automatic logic [3:0] exp_bp(input logic [1:0] md, input int p);
    case (md)
      2'b00: return (p == 0) ? 4'b1111 : 4'b0000;
      2'b01: return (p == 0) ? 4'b0101 : (p == 1) ? 4'b1010 : 4'b0000;
      2'b10: return (p == 0) ? 4'b0001 : (p == 1) ? 4'b1010 : (p == 2) ? 4'b0100 : 4'b0000;
      default: return 4'b0001 << p;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 24; i++) m_ram[i] = '0;
      m_stage = '0; m_disp = '0; m_ph = 0; m_pol = 1'b0;
    end else begin
      int n, nr;
      n = int'(mode) + 1;
      if (frame_tick) begin
        m_ph = (m_ph + 1 < n) ? m_ph + 1 : 0;
        if (m_ph == 0) m_pol = ~m_pol;
        m_disp = m_stage;
      end
      nr = (m_ph + 1 < n) ? m_ph + 1 : 0;
      for (int i = 0; i < 24; i++) m_stage[i] = m_ram[i][nr];
      if (wr_valid && !frame_tick && wr_addr < 5'd24) m_ram[wr_addr] = wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] eb;
      string bt;
      eb = exp_bp(mode, m_ph);
      case (mode)
        2'b00: bt = "R8";
        2'b01: bt = "R7";
        2'b10: bt = "R6";
        default: bt = "R5";
      endcase
      chk(seg_on == m_disp, "R3 R9 seg_on", 32'(seg_on), 32'(m_disp));
      chk(bp_active == eb, bt, 32'(bp_active), 32'(eb));
      chk(drive_pol == m_pol, "R4 R10 pol", 32'(drive_pol), 32'(m_pol));
      chk(seg_lvl == (m_disp ^ {24{m_pol}}), "R10 seg_lvl", 32'(seg_lvl), 32'(m_disp ^ {24{m_pol}}));
      chk(bp_lvl == (m_pol ? eb : ~eb), "R10 bp_lvl", 32'(bp_lvl), 32'(m_pol ? eb : ~eb));
      chk(wr_ready == !frame_tick, "R2 ready", 32'(wr_ready), 32'(!frame_tick));
    end
  end

  task automatic step_in(input bit t, input bit v, input logic [4:0] a, input logic [3:0] d);
    @(negedge clk); #1;
    frame_tick = t; wr_valid = v; wr_addr = a; wr_data = d;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(seg_on == '0, "R1 seg_on", 32'(seg_on), 0);
    chk(drive_pol == 1'b0, "R1 pol", 32'(drive_pol), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(bp_active == 4'b0001 && seg_lvl == '0, "R1 phase", 32'(bp_active), 1);
    for (int a = 0; a < 24; a++) step_in(0, 1, 5'(a), 4'((a * 7 + 3) & 15));
    // R2: beats refused on tick cycles and out-of-range addresses
    step_in(1, 1, 5'd2, 4'hF);
    step_in(0, 1, 5'd27, 4'hF);
    step_in(0, 0, '0, '0);
    for (int mi = 0; mi < 4; mi++) begin
      step_in(0, 0, '0, '0);
      mode = 2'(3 - mi);
      repeat (3) step_in(0, 0, '0, '0);
      for (int c = 0; c < 120; c++)
        step_in(($urandom % 4) == 0, ($urandom % 3) == 0, 5'($urandom % 32), 4'($urandom));
    end
    // R4: wrap from an out-of-range phase after a mode narrowing
    step_in(0, 0, '0, '0);
    mode = 2'b11;
    repeat (2) step_in(0, 0, '0, '0);
    repeat (3) step_in(1, 0, '0, '0);
    step_in(0, 0, '0, '0);
    mode = 2'b01;
    repeat (2) step_in(0, 0, '0, '0);
    repeat (3) step_in(1, 0, '0, '0);
    repeat (3) step_in(0, 0, '0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule